// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a time-of-day value for packet timestamping: a 32-bit seconds word and a 31-bit sub-second word. Each time the counter advances, the sub-second word grows by a programmable increment. When it reaches the rollover value it wraps, and the seconds word counts up by one. The rollover value is either 2^31 (binary units of about 0.465 ns) or 10^9 (decimal units of 1 ns).

Software runs the block through a small register port. It selects the advance mode and the rollover style, and it programs the increment. A 32-bit addend feeds an accumulator whose carry-out paces the counter in fine mode, which allows frequency trimming. Software can also load an absolute time, or step the time forwards or backwards. A backward step is written in complement form: 2^32 minus the seconds step, and the rollover value minus the sub-second step. The block then applies the borrow into seconds.

Command bits are set by a register write and cleared by the block on the clock edge where the command takes effect, so software can poll them. Reading the seconds word also latches the sub-second word, so a later sub-second read returns the matching half of the same instant.

Top module: `ptp_time_counter`

## Requirements
- R1: After synchronous reset, both time words are zero and the control register (address 0) reads zero. Zero selects coarse mode and binary rollover.
- R2: In coarse mode (control bit 0 = 0), the sub-second output grows by the increment register (address 1, bits 7:0) on every clock. A new increment is first used on the clock after the write.
- R3: With binary rollover (control bit 1 = 0), the sub-second value wraps modulo 2^31, and on that clock the seconds word increments by one.
- R4: With decimal rollover (control bit 1 = 1), the sub-second value wraps modulo 10^9, and on that clock the seconds word increments by one.
- R5: Writing 1 to control bit 2 (initialize) sets that bit. On the next clock the time becomes the seconds update register (address 3) and bits 30:0 of the sub-second update register (address 4), and the bit reads back 0.
- R6: Writing 1 to control bit 3 (step) adds the update registers to the time on the next clock, with bit 31 of address 4 clear meaning add. A sub-second sum at or above the rollover value is reduced by it and carries one into seconds. The bit then reads back 0.
- R7: When bit 31 of address 4 is set, a step subtracts. Address 3 must hold 2^32 minus the seconds step, and bits 30:0 of address 4 must hold the rollover value minus the sub-second step. A sub-second sum below the rollover value borrows one from seconds.
- R8: In fine mode (control bit 1... bit 0 = 1), the counter advances by the increment only on clocks that follow a carry-out of the 32-bit addend accumulator. With an addend of 2^31, that gives one advance in every two clocks.
- R9: A write to the addend register (address 2) has no effect on timekeeping until control bit 4 (load addend) is written. That bit reads back 0 once the accumulator has taken the value.
- R10: A read of address 5 returns the seconds word and, on the same edge, latches the sub-second word. A later read of address 6 returns that latched value.
- R11: Read data appears one clock after the read strobe. Addresses 1 to 4 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Registered read data, valid one clock after the strobe |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 31 | Current sub-seconds |

## Verification
A register write lands on one edge. A command written on edge N takes effect on edge N+1, and a new increment or mode is first used on the edge after its write. Every check therefore samples on a falling edge after counting exactly those edges.

Read data is registered, so the bench drives the strobe on a falling edge and samples the result on the next one. Fine-mode pacing is judged over a ten-clock window, which makes the result independent of the accumulator's phase. Wrap and borrow cases hold the increment at zero while the time is loaded, so the start value is exact.

// File: rtl/ptp_time_pkg.sv
// Package: shared widths, register addresses and control bit positions
// for the PTP system time counter. Assumes a 32-bit register port.
package ptp_time_pkg;
    localparam int SEC_W  = 32;
    localparam int NS_W   = 31;
    localparam int INC_W  = 8;
    localparam int ACC_W  = 32;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_INCR     = 3'd1,
        REG_ADDEND   = 3'd2,
        REG_SEC_UPD  = 3'd3,
        REG_NS_UPD   = 3'd4,
        REG_TIME_SEC = 3'd5,
        REG_TIME_NS  = 3'd6
    } reg_addr_e;

    localparam int CTL_FINE   = 0;
    localparam int CTL_DEC    = 1;
    localparam int CTL_INIT   = 2;
    localparam int CTL_STEP   = 3;
    localparam int CTL_ADDEND = 4;

    localparam logic [31:0] DEC_ROLL = 32'd1_000_000_000;
endpackage

// File: rtl/ptp_addend_acc.sv
// Fine-correction accumulator: adds the active addend every clock and
// registers the carry-out as the advance strobe. The active addend
// changes only on a load pulse. Assumes reset clears the phase.
module ptp_addend_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    output logic [ACC_W-1:0] addend_now,
    output logic             strobe
);
    logic [ACC_W-1:0] acc_q;

    // Latch a new addend and accumulate, keeping the carry as the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_now <= '0;
            acc_q      <= '0;
            strobe     <= 1'b0;
        end else begin
            if (load) addend_now <= load_val;
            {strobe, acc_q} <= {1'b0, acc_q} + {1'b0, addend_now};
        end
    end
endmodule

// File: rtl/ptp_time_core.sv
// Seconds / sub-seconds counter. The priority order is initialize,
// then step, then the increment tick. Sub-second results at or above
// the rollover value are normalized into seconds. Assumes the
// sub-second value is below the rollover value when a step is applied.
module ptp_time_core #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 31,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decimal,
    input  logic             tick,
    input  logic [INC_W-1:0] incr,
    input  logic             do_init,
    input  logic             do_step,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [NS_W-1:0]  upd_ns,
    input  logic             upd_sub,
    output logic [SEC_W-1:0] time_sec,
    output logic [NS_W-1:0]  time_ns
);
    import ptp_time_pkg::*;

    localparam logic [NS_W:0] BIN_ROLL = {1'b1, {NS_W{1'b0}}};

    logic [NS_W:0]  roll;
    logic [NS_W:0]  tick_sum, step_sum;
    logic           tick_wrap, step_wrap;
    logic [NS_W-1:0] tick_ns, step_ns;
    logic [SEC_W-1:0] step_sec;

    // Select the rollover value and form both candidate sums.
    always_comb begin
        roll      = decimal ? DEC_ROLL[NS_W:0] : BIN_ROLL;
        tick_sum  = {1'b0, time_ns} + {{(NS_W+1-INC_W){1'b0}}, incr};
        step_sum  = {1'b0, time_ns} + {1'b0, upd_ns};
        tick_wrap = (tick_sum >= roll);
        step_wrap = (step_sum >= roll);
        tick_ns   = tick_wrap ? NS_W'(tick_sum - roll) : tick_sum[NS_W-1:0];
        step_ns   = step_wrap ? NS_W'(step_sum - roll) : step_sum[NS_W-1:0];
        step_sec  = time_sec + upd_sec
                  + {{(SEC_W-1){1'b0}}, step_wrap}
                  - {{(SEC_W-1){1'b0}}, upd_sub};
    end

    // Update the running time from init, step or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_sec <= '0;
            time_ns  <= '0;
        end else if (do_init) begin
            time_sec <= upd_sec;
            time_ns  <= upd_ns;
        end else if (do_step) begin
            time_sec <= step_sec;
            time_ns  <= step_ns;
        end else if (tick) begin
            time_ns <= tick_ns;
            if (tick_wrap) time_sec <= time_sec + 1'b1;
        end
    end
endmodule

// File: rtl/ptp_time_counter.sv
// Top: register file, command sequencing and read port for the PTP
// system time counter. Commands execute one clock after they are
// written and clear themselves on that edge. Reads are registered.
module ptp_time_counter #(
    parameter int SEC_W  = ptp_time_pkg::SEC_W,
    parameter int NS_W   = ptp_time_pkg::NS_W,
    parameter int INC_W  = ptp_time_pkg::INC_W,
    parameter int ACC_W  = ptp_time_pkg::ACC_W,
    parameter int ADDR_W = ptp_time_pkg::ADDR_W,
    parameter int DATA_W = ptp_time_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic [SEC_W-1:0]  time_sec,
    output logic [NS_W-1:0]   time_ns
);
    import ptp_time_pkg::*;

    logic             ctrl_fine, ctrl_dec;
    logic             pend_init, pend_step, pend_addend;
    logic [INC_W-1:0] incr_q;
    logic [ACC_W-1:0] addend_reg;
    logic [SEC_W-1:0] sec_upd_q;
    logic [DATA_W-1:0] ns_upd_q;
    logic [NS_W-1:0]  ns_shadow;
    logic [ACC_W-1:0] addend_now;
    logic             acc_strobe;
    logic             ctrl_wr;
    logic             tick;

    assign ctrl_wr = reg_wr_en && (reg_wr_addr == REG_CTRL);
    assign tick    = ctrl_fine ? acc_strobe : 1'b1;

    // Control register: mode bits and self-clearing command bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_fine   <= 1'b0;
            ctrl_dec    <= 1'b0;
            pend_init   <= 1'b0;
            pend_step   <= 1'b0;
            pend_addend <= 1'b0;
        end else begin
            pend_init   <= 1'b0;
            pend_step   <= 1'b0;
            pend_addend <= 1'b0;
            if (ctrl_wr) begin
                ctrl_fine   <= reg_wr_data[CTL_FINE];
                ctrl_dec    <= reg_wr_data[CTL_DEC];
                pend_init   <= reg_wr_data[CTL_INIT];
                pend_step   <= reg_wr_data[CTL_STEP];
                pend_addend <= reg_wr_data[CTL_ADDEND];
            end
        end
    end

    // Data registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            incr_q     <= '0;
            addend_reg <= '0;
            sec_upd_q  <= '0;
            ns_upd_q   <= '0;
        end else if (reg_wr_en) begin
            case (reg_wr_addr)
                REG_INCR:    incr_q     <= reg_wr_data[INC_W-1:0];
                REG_ADDEND:  addend_reg <= reg_wr_data[ACC_W-1:0];
                REG_SEC_UPD: sec_upd_q  <= reg_wr_data[SEC_W-1:0];
                REG_NS_UPD:  ns_upd_q   <= reg_wr_data;
                default:     ;
            endcase
        end
    end

    // Registered read port with a coherent seconds/sub-seconds snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_data <= '0;
            ns_shadow   <= '0;
        end else if (reg_rd_en) begin
            case (reg_rd_addr)
                REG_CTRL:     reg_rd_data <= DATA_W'({pend_addend, pend_step,
                                                      pend_init, ctrl_dec, ctrl_fine});
                REG_INCR:     reg_rd_data <= DATA_W'(incr_q);
                REG_ADDEND:   reg_rd_data <= DATA_W'(addend_reg);
                REG_SEC_UPD:  reg_rd_data <= DATA_W'(sec_upd_q);
                REG_NS_UPD:   reg_rd_data <= ns_upd_q;
                REG_TIME_SEC: reg_rd_data <= DATA_W'(time_sec);
                REG_TIME_NS:  reg_rd_data <= DATA_W'(ns_shadow);
                default:      reg_rd_data <= '0;
            endcase
            if (reg_rd_addr == REG_TIME_SEC) ns_shadow <= time_ns;
        end
    end

    ptp_addend_acc #(.ACC_W(ACC_W)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pend_addend),
        .load_val   (addend_reg),
        .addend_now (addend_now),
        .strobe     (acc_strobe)
    );

    ptp_time_core #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .decimal  (ctrl_dec),
        .tick     (tick),
        .incr     (incr_q),
        .do_init  (pend_init),
        .do_step  (pend_step),
        .upd_sec  (sec_upd_q),
        .upd_ns   (ns_upd_q[NS_W-1:0]),
        .upd_sub  (ns_upd_q[DATA_W-1]),
        .time_sec (time_sec),
        .time_ns  (time_ns)
    );
endmodule

// File: rtl/ptp_time_checker.sv
// Checker for ptp_time_counter: relates the command, counter and read
// paths across clocks. It is attached to the top with bind.
module ptp_time_checker #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 31,
    parameter int INC_W = 8,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             ctrl_fine,
    input logic             ctrl_dec,
    input logic             pend_init,
    input logic             pend_step,
    input logic [INC_W-1:0] incr_q,
    input logic [SEC_W-1:0] sec_upd_q,
    input logic [ACC_W-1:0] addend_now,
    input logic             acc_strobe,
    input logic             reg_rd_en,
    input logic [2:0]       reg_rd_addr,
    input logic [NS_W-1:0]  ns_shadow,
    input logic [SEC_W-1:0] time_sec,
    input logic [NS_W-1:0]  time_ns
);
    logic [NS_W:0] roll_c, tick_sum_c;
    logic          idle_c;
    assign roll_c     = ctrl_dec ? (NS_W+1)'(1_000_000_000) : {1'b1, {NS_W{1'b0}}};
    assign tick_sum_c = {1'b0, time_ns} + (NS_W+1)'(incr_q);
    assign idle_c     = !pend_init && !pend_step && !ctrl_fine;

    // R2
    coarse_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_c && tick_sum_c < roll_c) |=> time_ns == NS_W'($past(tick_sum_c)));

    // R3
    bin_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_c && !ctrl_dec && tick_sum_c[NS_W]) |=> time_sec == $past(time_sec) + 1'b1);

    // R5
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_init && !ctrl_wr) |=> !pend_init);

    // R5
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_init |=> time_sec == $past(sec_upd_q));

    // R9
    zero_addend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addend_now == '0) |=> !acc_strobe);

    // R10
    snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_rd_addr == 3'd5) |=> ns_shadow == $past(time_ns));
endmodule

bind ptp_time_counter ptp_time_checker #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .ACC_W(ACC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_fine  (ctrl_fine),
    .ctrl_dec   (ctrl_dec),
    .pend_init  (pend_init),
    .pend_step  (pend_step),
    .incr_q     (incr_q),
    .sec_upd_q  (sec_upd_q),
    .addend_now (addend_now),
    .acc_strobe (acc_strobe),
    .reg_rd_en  (reg_rd_en),
    .reg_rd_addr(reg_rd_addr),
    .ns_shadow  (ns_shadow),
    .time_sec   (time_sec),
    .time_ns    (time_ns)
);

// File: tb/ptp_time_counter_tb.sv
// Directed bench for ptp_time_counter: one task per scenario.
module ptp_time_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DEC = 32'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic [31:0] time_sec;
    logic [30:0] time_ns;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_counter dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .time_sec(time_sec), .time_ns(time_ns)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd_en = 1'b1; reg_rd_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rd_data;
    endtask

    // Control write followed by the edge on which the command acts.
    task automatic cmd(input logic [31:0] d);
        wr(3'd0, d);
        @(negedge clk);
    endtask

    task automatic load_time(input logic [31:0] s, input logic [30:0] n, input logic dec);
        wr(3'd1, 32'd0);
        wr(3'd3, s);
        wr(3'd4, {1'b0, n});
        cmd({27'd0, 1'b0, 1'b0, 1'b1, dec, 1'b0});
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 sec", time_sec, 0);
        check("R1 ns", time_ns, 0);
        rd(3'd0, r);
        check("R1 ctrl", r, 0);
    endtask

    task automatic t_init();
        logic [31:0] r;
        load_time(32'd7, 31'd100, 1'b0);
        check("R5 sec", time_sec, 7);
        check("R5 ns", time_ns, 100);
        rd(3'd0, r);
        check("R5 init bit cleared", r[2], 0);
        rd(3'd3, r);
        check("R11 sec_upd readback", r, 7);
    endtask

    task automatic t_coarse();
        logic [31:0] r;
        wr(3'd1, 32'd5);
        check("R2 new incr not yet used", time_ns, 100);
        repeat (8) @(negedge clk);
        check("R2 eight ticks", time_ns, 140);
        rd(3'd1, r);
        check("R11 incr readback", r, 5);
    endtask

    task automatic t_bin_wrap();
        load_time(32'd9, 31'h7FFF_FFFD, 1'b0);
        wr(3'd1, 32'd5);
        @(negedge clk);
        check("R3 ns wrap", time_ns, 2);
        check("R3 sec carry", time_sec, 10);
    endtask

    task automatic t_dec_wrap();
        load_time(32'd30, 31'(DEC - 4), 1'b1);
        check("R4 init ns", time_ns, DEC - 4);
        wr(3'd1, 32'd10);
        @(negedge clk);
        check("R4 ns wrap", time_ns, 6);
        check("R4 sec carry", time_sec, 31);
    endtask

    task automatic t_step_fwd();
        logic [31:0] r;
        load_time(32'd20, 31'd999_999_990, 1'b1);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd15);
        cmd(32'h0000_000A);
        check("R6 ns normalized", time_ns, 5);
        check("R6 sec carry", time_sec, 24);
        rd(3'd0, r);
        check("R6 step bit cleared", r[3], 0);
    endtask

    task automatic t_step_back();
        load_time(32'd20, 31'd10, 1'b1);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, {1'b1, 31'(DEC - 30)});
        cmd(32'h0000_000A);
        check("R7 borrow ns", time_ns, DEC - 20);
        check("R7 borrow sec", time_sec, 18);
        load_time(32'd20, 31'd50, 1'b1);
        wr(3'd3, 32'd0);
        wr(3'd4, {1'b1, 31'(DEC - 30)});
        cmd(32'h0000_000A);
        check("R7 no-borrow ns", time_ns, 20);
        check("R7 no-borrow sec", time_sec, 20);
    endtask

    task automatic t_fine();
        logic [30:0] n0;
        logic [31:0] r;
        wr(3'd1, 32'd20);
        wr(3'd0, 32'h0000_0003);
        n0 = time_ns;
        wr(3'd2, 32'h8000_0000);
        repeat (10) @(negedge clk);
        check("R9 addend write alone ignored", time_ns, n0);
        cmd(32'h0000_0013);
        rd(3'd0, r);
        check("R9 addend bit cleared", r[4], 0);
        rd(3'd2, r);
        check("R11 addend readback", r, 32'h8000_0000);
        n0 = time_ns;
        repeat (10) @(negedge clk);
        check("R8 half-rate advance", time_ns - n0, 100);
    endtask

    task automatic t_coherent();
        logic [31:0] s, r;
        logic [30:0] n;
        wr(3'd0, 32'h0000_0002);
        @(negedge clk);
        s = time_sec; n = time_ns;
        rd(3'd5, r);
        check("R10 sec read", r, s);
        repeat (3) @(negedge clk);
        rd(3'd6, r);
        check("R10 coherent ns", r, n);
        check("R10 time kept moving", time_ns != n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_coarse();
        t_bin_wrap();
        t_dec_wrap();
        t_step_fwd();
        t_step_back();
        t_fine();
        t_coherent();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule